// File: doc/BRIEF.md
# Low-Transition Self-Test Vector Source

This block produces stimulus words for on-chip self-test where consecutive words should differ in few bits. An 8-stage shift register with selectable feedback (a Johnson-style counter) is XORed bit by bit with a seed word taken from an 8-bit maximal-length LFSR. While the Johnson counter steps, the seed stays fixed. One full Johnson cycle therefore walks a small set of bit changes over the same seed. After that cycle the controller advances the seed and the walk repeats.

Two synchronous enables on a single clock drive the block. One advances the seed and the other advances the Johnson counter. A 2-bit mode input chooses the Johnson feedback: clear, rotate or invert. Every step produces a registered vector and a one-cycle valid strobe. A flag marks the vector that completes the sixteenth Johnson step under the current seed.

Top module: `msic_pattern_gen`

## Requirements
- R1: A synchronous active-high reset drives vec_out to 0, vec_valid to 0 and seed_end to 0. It also clears every Johnson stage, loads the seed with SEED_INIT (default 8'h0D) and zeroes the step count. A normal-mode Johnson step taken right after reset therefore yields 8'h0C.
- R2: With jc_mode = 2'b00 (normal), a Johnson step shifts the stages one place toward bit 7, and bit 0 takes the inverse of the old bit 7. This gives a 16-step period.
- R3: With jc_mode = 2'b01 (circular), a Johnson step shifts toward bit 7, and bit 0 takes the old bit 7 unchanged.
- R4: With jc_mode = 2'b10 or 2'b11 (clear), a Johnson step shifts toward bit 7 and bit 0 takes 0. Eight such steps empty the counter, after which vec_out equals the seed.
- R5: After any step, vec_out equals the new Johnson state XOR the new seed. It appears on the clock edge that applies the step.
- R6: A seed step replaces the seed s with {s[6:0], s[7]^s[5]^s[4]^s[3]} (polynomial x^8+x^6+x^5+x^4+1). It leaves the Johnson state unchanged and zeroes the step count.
- R7: vec_valid is high for exactly the one cycle after each edge on which a step was applied, and low otherwise. With no step, vec_out holds its value.
- R8: seed_end is high, together with vec_valid, on the vector of the 16th Johnson step counted since reset or the last seed step. After that the count wraps, so every further 16th step raises it again.
- R9: When both enables are high in the same cycle, only the seed advances. The Johnson state and the step count stay unchanged, and seed_end stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seed_step | input | 1 | Advance the LFSR seed this cycle |
| jc_step | input | 1 | Advance the Johnson counter this cycle |
| jc_mode | input | 2 | Johnson feedback: 00 normal, 01 circular, 1x clear |
| vec_out | output | 8 | Registered test vector |
| vec_valid | output | 1 | One-cycle strobe for a new vector |
| seed_end | output | 1 | Marks the 16th Johnson vector under the current seed |

## Verification
The seed advance and the Johnson advance can be requested in the same cycle. The bench provokes this by raising both enables together in the middle of a Johnson walk. It judges the result by three things. The vector must equal the untouched Johnson state XOR the advanced seed, with no end flag. The next Johnson step must continue from the state held before the collision. The end flag must then wait a full sixteen further Johnson steps.

// File: rtl/msic_pkg.sv
package msic_pkg;

  typedef enum logic [1:0] {
    JM_NORMAL    = 2'b00,
    JM_CIRC      = 2'b01,
    JM_CLEAR     = 2'b10,
    JM_CLEAR_ALT = 2'b11
  } jc_mode_e;

endpackage

// File: rtl/msic_johnson.sv
module msic_johnson #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic [1:0]   mode,
  output logic [W-1:0] q,
  output logic [W-1:0] nxt
);
  import msic_pkg::*;

  jc_mode_e mode_e;
  logic     mux_sel;
  logic     gate_en;
  logic     gate_out;
  logic     fb;

  assign mode_e   = jc_mode_e'(mode);
  // Select 1 routes the gated last stage, select 0 routes its inverse.
  assign mux_sel  = (mode_e != JM_NORMAL);
  assign gate_en  = (mode_e == JM_CIRC);
  assign gate_out = gate_en & q[W-1];
  assign fb       = mux_sel ? gate_out : ~q[W-1];

  assign nxt[0] = fb;
  for (genvar i = 1; i < W; i++) begin : g_stage
    assign nxt[i] = q[i-1];
  end

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (adv) q <= nxt;
  end
endmodule

// File: rtl/msic_lfsr.sv
module msic_lfsr #(
  parameter int           W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] INIT = 8'h0D
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] q,
  output logic [W-1:0] nxt
);
  assign nxt = {q[W-2:0], ^(q & TAPS)};

  always_ff @(posedge clk) begin
    if (rst)      q <= INIT;
    else if (adv) q <= nxt;
  end
endmodule

// File: rtl/msic_step_count.sv
module msic_step_count #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  output logic last
);
  localparam int CNT_W = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CNT_W-1:0] TOP = CNT_W'(LEN - 1);

  logic [CNT_W-1:0] cnt;

  assign last = adv & (cnt == TOP);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (adv)    cnt <= (cnt == TOP) ? '0 : cnt + CNT_W'(1);
  end
endmodule

// File: rtl/msic_pattern_gen.sv
module msic_pattern_gen #(
  parameter int                STAGES    = 8,
  parameter logic [STAGES-1:0] TAPS      = 8'hB8,
  parameter logic [STAGES-1:0] SEED_INIT = 8'h0D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seed_step,
  input  logic              jc_step,
  input  logic [1:0]        jc_mode,
  output logic [STAGES-1:0] vec_out,
  output logic              vec_valid,
  output logic              seed_end
);
  localparam int WALK_LEN = 2 * STAGES;

  logic              jc_adv;
  logic              walk_last;
  logic [STAGES-1:0] jc_q, jc_nxt;
  logic [STAGES-1:0] sd_q, sd_nxt;

  // Seed advance wins over a simultaneous Johnson advance.
  assign jc_adv = jc_step & ~seed_step;

  msic_johnson #(.W(STAGES)) u_jc (
    .clk(clk), .rst(rst), .adv(jc_adv), .mode(jc_mode),
    .q(jc_q), .nxt(jc_nxt)
  );

  msic_lfsr #(.W(STAGES), .TAPS(TAPS), .INIT(SEED_INIT)) u_seed (
    .clk(clk), .rst(rst), .adv(seed_step),
    .q(sd_q), .nxt(sd_nxt)
  );

  msic_step_count #(.LEN(WALK_LEN)) u_cnt (
    .clk(clk), .rst(rst), .clr(seed_step), .adv(jc_adv),
    .last(walk_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_out   <= '0;
      vec_valid <= 1'b0;
      seed_end  <= 1'b0;
    end else begin
      vec_valid <= seed_step | jc_step;
      seed_end  <= walk_last;
      if (seed_step)   vec_out <= jc_q ^ sd_nxt;
      else if (jc_step) vec_out <= jc_nxt ^ sd_q;
    end
  end
endmodule

// File: rtl/msic_pattern_gen_chk.sv
module msic_pattern_gen_chk #(
  parameter int STAGES = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              seed_step,
  input logic              jc_step,
  input logic [1:0]        jc_mode,
  input logic [STAGES-1:0] vec_out,
  input logic              vec_valid,
  input logic              seed_end,
  input logic [STAGES-1:0] jc_q,
  input logic [STAGES-1:0] sd_q
);
  assert_normal_fb_R2: assert property (@(posedge clk) disable iff (rst)
    (jc_step && !seed_step && jc_mode == 2'b00) |=> (jc_q[0] == !$past(jc_q[STAGES-1])));

  assert_circ_fb_R3: assert property (@(posedge clk) disable iff (rst)
    (jc_step && !seed_step && jc_mode == 2'b01) |=> (jc_q[0] == $past(jc_q[STAGES-1])));

  assert_clear_fb_R4: assert property (@(posedge clk) disable iff (rst)
    (jc_step && !seed_step && jc_mode[1]) |=> !jc_q[0]);

  assert_vec_is_xor_R5: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> (vec_out == (jc_q ^ sd_q)));

  assert_seed_keeps_jc_R6: assert property (@(posedge clk) disable iff (rst)
    seed_step |=> $stable(jc_q));

  assert_valid_on_step_R7: assert property (@(posedge clk) disable iff (rst)
    (seed_step || jc_step) |=> vec_valid);

  assert_valid_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !(seed_step || jc_step) |=> (!vec_valid && $stable(vec_out)));

  assert_end_has_valid_R8: assert property (@(posedge clk) disable iff (rst)
    seed_end |-> vec_valid);

  assert_both_seed_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (seed_step && jc_step) |=> (vec_valid && !seed_end && $stable(jc_q)));
endmodule

bind msic_pattern_gen msic_pattern_gen_chk #(.STAGES(STAGES)) u_chk (
  .clk(clk), .rst(rst), .seed_step(seed_step), .jc_step(jc_step),
  .jc_mode(jc_mode), .vec_out(vec_out), .vec_valid(vec_valid),
  .seed_end(seed_end), .jc_q(jc_q), .sd_q(sd_q)
);

// File: tb/sim_msic_pattern_gen.sv
module sim_msic_pattern_gen;
  localparam int CLK_P = 10;
  localparam int NROW  = 13;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       seed_step = 1'b0;
  logic       jc_step = 1'b0;
  logic [1:0] jc_mode = 2'b00;
  logic [7:0] vec_out;
  logic       vec_valid;
  logic       seed_end;

  int checks = 0;
  int errors = 0;

  // {seed_step, jc_step, mode, expected vec, expected valid, expected end}
  localparam logic [13:0] TBL [NROW] = '{
    {1'b0, 1'b1, 2'b00, 8'h0C, 1'b1, 1'b0},  // R2 R5 first step after reset
    {1'b0, 1'b1, 2'b00, 8'h0E, 1'b1, 1'b0},  // R2
    {1'b0, 1'b0, 2'b00, 8'h0E, 1'b0, 1'b0},  // R7 idle holds
    {1'b0, 1'b1, 2'b01, 8'h0B, 1'b1, 1'b0},  // R3
    {1'b0, 1'b1, 2'b00, 8'h00, 1'b1, 1'b0},  // R2
    {1'b1, 1'b0, 2'b00, 8'h16, 1'b1, 1'b0},  // R6 seed 0D->1B
    {1'b1, 1'b1, 2'b00, 8'h3B, 1'b1, 1'b0},  // R9 seed 1B->36, jc kept
    {1'b0, 1'b1, 2'b10, 8'h2C, 1'b1, 1'b0},  // R4
    {1'b0, 1'b1, 2'b11, 8'h02, 1'b1, 1'b0},  // R4 alt code
    {1'b0, 1'b1, 2'b01, 8'h5E, 1'b1, 1'b0},  // R3
    {1'b0, 1'b1, 2'b01, 8'hE6, 1'b1, 1'b0},  // R3
    {1'b0, 1'b1, 2'b01, 8'h97, 1'b1, 1'b0},  // R3 bit7 wraps
    {1'b0, 1'b1, 2'b00, 8'h74, 1'b1, 1'b0}   // R2
  };

  msic_pattern_gen u0 (
    .clk(clk), .rst(rst), .seed_step(seed_step), .jc_step(jc_step),
    .jc_mode(jc_mode), .vec_out(vec_out), .vec_valid(vec_valid),
    .seed_end(seed_end)
  );

  always #(CLK_P/2) clk = ~clk;

  // Reference state built from the requirement text.
  logic [7:0] m_jc, m_sd, m_vec;
  int         m_cnt;
  logic       m_end;

  function automatic logic [7:0] jc_next(logic [7:0] s, logic [1:0] m);
    logic fb;
    fb = (m == 2'b00) ? ~s[7] : (m == 2'b01) ? s[7] : 1'b0;
    return {s[6:0], fb};
  endfunction

  function automatic logic [7:0] sd_next(logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic ss, input logic js, input logic [1:0] m);
    @(negedge clk);
    seed_step = ss; jc_step = js; jc_mode = m;
    @(posedge clk);
    #1;
    seed_step = 1'b0; jc_step = 1'b0;
    m_end = 1'b0;
    if (ss) begin
      m_sd = sd_next(m_sd); m_cnt = 0;
    end else if (js) begin
      m_jc = jc_next(m_jc, m);
      m_end = (m_cnt == 15);
      m_cnt = (m_cnt + 1) % 16;
    end
    if (ss || js) m_vec = m_jc ^ m_sd;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; seed_step = 1'b0; jc_step = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    m_jc = 8'h00; m_sd = 8'h0D; m_cnt = 0; m_vec = 8'h00; m_end = 1'b0;
  endtask

  task automatic model_check(input string req);
    check(req, {24'h0, vec_out}, {24'h0, m_vec});
    check(req, {31'h0, seed_end}, {31'h0, m_end});
  endtask

  initial begin
    #(CLK_P * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    check("R1 vec", {24'h0, vec_out}, 32'h0);
    check("R1 valid", {31'h0, vec_valid}, 32'h0);
    check("R1 end", {31'h0, seed_end}, 32'h0);

    // Table walk
    for (int i = 0; i < NROW; i++) begin
      apply(TBL[i][13], TBL[i][12], TBL[i][11:10]);
      check($sformatf("table row %0d R2 R3 R4 R5 R6 R9 vec", i), {24'h0, vec_out}, {24'h0, TBL[i][9:2]});
      check($sformatf("table row %0d R7 valid", i), {31'h0, vec_valid}, {31'h0, TBL[i][1]});
      check($sformatf("table row %0d R8 end", i), {31'h0, seed_end}, {31'h0, TBL[i][0]});
    end

    // R8: 32 normal steps, end flag on the 16th and 32nd; R2 period of 16
    do_reset();
    for (int k = 0; k < 32; k++) begin
      apply(1'b0, 1'b1, 2'b00);
      model_check("R8 walk");
    end
    check("R2 period returns", {24'h0, vec_out}, 32'h0D);

    // R6/R8: seed step mid-walk restarts the count
    for (int k = 0; k < 10; k++) apply(1'b0, 1'b1, 2'b00);
    apply(1'b1, 1'b0, 2'b00);
    model_check("R6 seed step");
    for (int k = 0; k < 16; k++) begin
      apply(1'b0, 1'b1, 2'b01);
      model_check("R8 after seed");
    end

    // R9 collision mid-walk, then count still needs 16 steps
    for (int k = 0; k < 5; k++) apply(1'b0, 1'b1, 2'b00);
    apply(1'b1, 1'b1, 2'b00);
    model_check("R9 both steps");
    for (int k = 0; k < 16; k++) begin
      apply(1'b0, 1'b1, 2'b00);
      model_check("R9 walk after collision");
    end

    // R4: eight clear steps leave vec equal to the seed
    for (int k = 0; k < 8; k++) apply(1'b0, 1'b1, 2'b10);
    check("R4 emptied", {24'h0, vec_out}, {24'h0, m_sd});
    model_check("R4 model");

    // R7: idle cycle holds vector, no valid
    apply(1'b0, 1'b0, 2'b00);
    check("R7 idle valid", {31'h0, vec_valid}, 32'h0);
    model_check("R7 idle hold");

    // R1: reset mid-run, then first normal step gives 0C
    for (int k = 0; k < 3; k++) apply(1'b0, 1'b1, 2'b01);
    do_reset();
    check("R1 mid-run vec", {24'h0, vec_out}, 32'h0);
    apply(1'b0, 1'b1, 2'b00);
    check("R1 first step", {24'h0, vec_out}, 32'h0C);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule